// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetch Engine

This block feeds a display pipeline with frame data from memory. Software gives it the address of a first descriptor. The engine reads that descriptor as a four-word burst: the link to the following descriptor, the start address of the frame data, an identifier word and a command word. It then streams the requested number of 32-bit words from the frame address into an internal pixel FIFO, using read bursts of a selectable size. When the frame is done it moves on to the linked descriptor. A descriptor that links to itself therefore refreshes the same frame without end.

The command word carries the transfer length and three per-frame request bits: a start-of-frame interrupt request, an end-of-frame interrupt request and a palette marker. Three sticky flags record the start-of-frame event, the end-of-frame event and the FIFO underrun event. Each flag has an enable for the combined interrupt line and a clear bit of its own. The memory side is a request/ready port with a separate stream of read-valid words. The display side pops words from the FIFO.

Top module: `frame_fetch_dma`

## Requirements
- R1: A pulse on `descAddrWr` while `busy` is low starts the engine. `busy` goes high, and the first memory request has `memAddr` equal to `descAddrIn` and `memLen` equal to 4. The four returned words are taken in this order: next-descriptor address, frame address, identifier, command.
- R2: The engine fetches exactly command[23:0] words, starting at the frame address and moving up in steps of 4 bytes. It pushes them into the FIFO in order, and `pixData` presents them in the same order.
- R3: `burstSel` sets the burst size: 0 gives 4 words, 1 gives 8 words, 2 or 3 gives 16 words. Each data request asks for a full burst. The last request of a frame asks only for the words that remain.
- R4: After the last word of a frame, the engine fetches the descriptor at that frame's next-descriptor address. A descriptor that links to itself repeats its frame.
- R5: `sofFlag` sets when a descriptor with command bit 31 set is loaded. `eofFlag` sets after the last word of a frame whose command bit 30 is set. A descriptor that has these bits clear does not set the flags.
- R6: When a descriptor is loaded, `frameId` takes that descriptor's identifier word and `palFlag` takes command bit 28.
- R7: No data request is issued unless the FIFO has room for a full burst. If the display stops popping, fetching stalls with `memReq` low and no word is lost.
- R8: `ufFlag` sets when `pixPop` is high, `pixEmpty` is high and `activeVideo` is high. A pop on an empty FIFO while `activeVideo` is low leaves the flag unchanged.
- R9: `flagClr` bit 0 clears `sofFlag`, bit 1 clears `eofFlag` and bit 2 clears `ufFlag`. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq` is the OR of (`sofFlag` and `sofIrqEn`), (`eofFlag` and `eofIrqEn`) and (`ufFlag` and `ufIrqEn`).
- R11: A pulse on `descAddrWr` while `busy` is high is ignored.
- R12: Once `memReq` is raised, it stays high with `memAddr` and `memLen` unchanged until a cycle in which `memRdy` is high.
- R13: After reset: `memReq`, `busy`, all flags and `irq` are low, `pixEmpty` is high, and `frameId` and `palFlag` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descAddrWr | input | 1 | Start strobe carrying the first descriptor address |
| descAddrIn | input | 32 | First descriptor byte address |
| burstSel | input | 2 | Burst size select |
| sofIrqEn | input | 1 | Start-of-frame interrupt enable |
| eofIrqEn | input | 1 | End-of-frame interrupt enable |
| ufIrqEn | input | 1 | Underrun interrupt enable |
| flagClr | input | 3 | Flag clear strobes (bit 0 start, bit 1 end, bit 2 underrun) |
| memReq | output | 1 | Read burst request |
| memRdy | input | 1 | Request accepted this cycle |
| memAddr | output | 32 | Burst start byte address |
| memLen | output | 5 | Burst length in words |
| memRdValid | input | 1 | Read data word valid |
| memRdData | input | 32 | Read data word |
| pixPop | input | 1 | Display pops the FIFO head |
| activeVideo | input | 1 | Display is in the visible region |
| pixData | output | 32 | FIFO head word |
| pixEmpty | output | 1 | FIFO empty |
| busy | output | 1 | Engine running |
| frameId | output | 32 | Identifier of the last loaded descriptor |
| palFlag | output | 1 | Palette marker of the last loaded descriptor |
| sofFlag | output | 1 | Sticky start-of-frame flag |
| eofFlag | output | 1 | Sticky end-of-frame flag |
| ufFlag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Combined interrupt |

## Verification
The FIFO push from an arriving read word and the display's pop can land in the same cycle. The popping monitor runs freely while bursts with gapped valid words arrive, so such cycles happen often; the scoreboard judges them by word order and the absence of loss, together with a stall phase that fills the FIFO to its limit. A flag set and its clear can also coincide. The bench provokes this by driving an underrun pop and the underrun clear bit on the same edge, and then expects the flag to read high.

// File: rtl/frame_fetch_pkg.sv
package frame_fetch_pkg;
  localparam int MAX_BURST = 16;
  localparam int LEN_W     = 24;
  localparam int CMD_SOF   = 31;
  localparam int CMD_EOF   = 30;
  localparam int CMD_PAL   = 28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DRX, ST_CHK, ST_BREQ, ST_BRX
  } fetchState_t;

  typedef struct packed {
    logic loadStart;
    logic loadNext;
    logic accept;
    logic capDesc;
    logic capData;
    logic eofSet;
    logic descKind;
  } fetchStb_t;
endpackage

// File: rtl/frame_fetch_ctrl.sv
module frame_fetch_ctrl
  import frame_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      descAddrWr,
  input  logic      memRdy,
  input  logic      wordsDone,
  input  logic      roomOk,
  input  logic      xferLast,
  output fetchStb_t stb,
  output logic      memReq,
  output logic      busy
);
  fetchState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    memReq    = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (descAddrWr) begin
        stb.loadStart = 1'b1;
        nextState     = ST_DREQ;
      end
      ST_DREQ: begin
        stb.descKind = 1'b1;
        memReq       = 1'b1;
        if (memRdy) begin
          stb.accept = 1'b1;
          nextState  = ST_DRX;
        end
      end
      ST_DRX: begin
        stb.descKind = 1'b1;
        stb.capDesc  = 1'b1;
        if (xferLast) nextState = ST_CHK;
      end
      ST_CHK: begin
        if (wordsDone) begin
          stb.eofSet   = 1'b1;
          stb.loadNext = 1'b1;
          nextState    = ST_DREQ;
        end else if (roomOk) begin
          nextState = ST_BREQ;
        end
      end
      ST_BREQ: begin
        memReq = 1'b1;
        if (memRdy) begin
          stb.accept = 1'b1;
          nextState  = ST_BRX;
        end
      end
      ST_BRX: begin
        stb.capData = 1'b1;
        if (xferLast) nextState = ST_CHK;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R1: a start while idle leads to a descriptor request
  p_start_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && descAddrWr) |=> (memReq && stb.descKind));

  // R11: a start pulse while running leaves the engine running, not restarted
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && descAddrWr) |=> busy);
endmodule

// File: rtl/frame_fetch_dp.sv
module frame_fetch_dp
  import frame_fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  localparam int PTR_W = $clog2(FIFO_DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int BL_W  = $clog2(MAX_BURST) + 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  fetchStb_t        stb,
  input  logic [31:0]      descAddrIn,
  input  logic [1:0]       burstSel,
  input  logic             memRdValid,
  input  logic [31:0]      memRdData,
  output logic [31:0]      memAddr,
  output logic [BL_W-1:0]  memLen,
  output logic             wordsDone,
  output logic             roomOk,
  output logic             xferLast,
  input  logic             pixPop,
  input  logic             activeVideo,
  input  logic [2:0]       flagClr,
  output logic [31:0]      pixData,
  output logic             pixEmpty,
  output logic [31:0]      frameId,
  output logic             palFlag,
  output logic [2:0]       flags
);
  logic [31:0]      descPtr, nextPtr, dataAddr, idHold, cmdHold;
  logic [LEN_W-1:0] wordsLeft;
  logic [BL_W-1:0]  xferLeft, burstWords;
  logic [1:0]       descIdx;
  logic [31:0]      fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fifoCnt;
  logic             rxWord, push, pop, cmdCap;

  always_comb begin
    unique case (burstSel)
      2'd0:    burstWords = BL_W'(4);
      2'd1:    burstWords = BL_W'(8);
      default: burstWords = BL_W'(MAX_BURST);
    endcase
  end

  assign rxWord    = memRdValid && (stb.capDesc || stb.capData);
  assign cmdCap    = memRdValid && stb.capDesc && (descIdx == 2'd3);
  assign xferLast  = rxWord && (xferLeft == BL_W'(1));
  assign wordsDone = (wordsLeft == '0);
  assign memAddr   = stb.descKind ? descPtr : dataAddr;

  always_comb begin
    if (stb.descKind)                        memLen = BL_W'(4);
    else if (wordsLeft < LEN_W'(burstWords)) memLen = BL_W'(wordsLeft);
    else                                     memLen = burstWords;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr <= '0; nextPtr <= '0; dataAddr <= '0; idHold <= '0; cmdHold <= '0;
      wordsLeft <= '0; xferLeft <= '0; descIdx <= '0; frameId <= '0; palFlag <= 1'b0;
    end else begin
      if (stb.loadStart)     descPtr <= descAddrIn;
      else if (stb.loadNext) descPtr <= nextPtr;
      if (stb.accept) begin
        xferLeft <= memLen;
        descIdx  <= '0;
      end else if (rxWord) begin
        xferLeft <= xferLeft - BL_W'(1);
      end
      if (memRdValid && stb.capDesc) begin
        descIdx <= descIdx + 2'd1;
        unique case (descIdx)
          2'd0: nextPtr  <= memRdData;
          2'd1: dataAddr <= memRdData;
          2'd2: idHold   <= memRdData;
          default: begin
            cmdHold   <= memRdData;
            wordsLeft <= memRdData[LEN_W-1:0];
            frameId   <= idHold;
            palFlag   <= memRdData[CMD_PAL];
          end
        endcase
      end
      if (push) begin
        dataAddr  <= dataAddr + 32'd4;
        wordsLeft <= wordsLeft - LEN_W'(1);
      end
    end
  end

  // pixel FIFO
  assign push     = memRdValid && stb.capData;
  assign pixEmpty = (fifoCnt == '0);
  assign pop      = pixPop && !pixEmpty;
  assign pixData  = fifoMem[rdPtr];
  assign roomOk   = (CNT_W'(FIFO_DEPTH) - fifoCnt) >= CNT_W'(burstWords);

  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= memRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; fifoCnt <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= rdPtr + PTR_W'(1);
      fifoCnt <= fifoCnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // sticky flags: bit0 start-of-frame, bit1 end-of-frame, bit2 underrun
  logic [2:0] flagSet;
  assign flagSet[0] = cmdCap && memRdData[CMD_SOF];
  assign flagSet[1] = stb.eofSet && cmdHold[CMD_EOF];
  assign flagSet[2] = pixPop && pixEmpty && activeVideo;

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= flagSet | (flags & ~flagClr);
  end

  // R7: the control never pushes into a full FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (fifoCnt < CNT_W'(FIFO_DEPTH)));

  // R8: an empty pop in active video leaves the underrun flag high
  p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixPop && pixEmpty && activeVideo) |=> flags[2]);

  // R2: pointer distance matches the occupancy count
  p_fifo_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    pixEmpty |-> (wrPtr == rdPtr));
endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma
  import frame_fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        descAddrWr,
  input  logic [31:0] descAddrIn,
  input  logic [1:0]  burstSel,
  input  logic        sofIrqEn,
  input  logic        eofIrqEn,
  input  logic        ufIrqEn,
  input  logic [2:0]  flagClr,
  output logic        memReq,
  input  logic        memRdy,
  output logic [31:0] memAddr,
  output logic [4:0]  memLen,
  input  logic        memRdValid,
  input  logic [31:0] memRdData,
  input  logic        pixPop,
  input  logic        activeVideo,
  output logic [31:0] pixData,
  output logic        pixEmpty,
  output logic        busy,
  output logic [31:0] frameId,
  output logic        palFlag,
  output logic        sofFlag,
  output logic        eofFlag,
  output logic        ufFlag,
  output logic        irq
);
  fetchStb_t  stb;
  logic       wordsDone, roomOk, xferLast;
  logic [2:0] flags;

  frame_fetch_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .descAddrWr(descAddrWr), .memRdy(memRdy),
    .wordsDone(wordsDone), .roomOk(roomOk), .xferLast(xferLast),
    .stb(stb), .memReq(memReq), .busy(busy)
  );

  frame_fetch_dp #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .descAddrIn(descAddrIn), .burstSel(burstSel),
    .memRdValid(memRdValid), .memRdData(memRdData), .memAddr(memAddr), .memLen(memLen),
    .wordsDone(wordsDone), .roomOk(roomOk), .xferLast(xferLast),
    .pixPop(pixPop), .activeVideo(activeVideo), .flagClr(flagClr),
    .pixData(pixData), .pixEmpty(pixEmpty), .frameId(frameId), .palFlag(palFlag),
    .flags(flags)
  );

  assign sofFlag = flags[0];
  assign eofFlag = flags[1];
  assign ufFlag  = flags[2];
  assign irq = (sofFlag && sofIrqEn) || (eofFlag && eofIrqEn) || (ufFlag && ufIrqEn);

  // R12: a pending request holds address and length until accepted
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> (memReq && $stable(memAddr) && $stable(memLen)));

  // R3: burst length is never zero and never above the largest burst
  p_burst_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memLen != 5'd0 && memLen <= 5'(MAX_BURST)));

  // R7: a data request only goes out with room for a whole burst
  p_room_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !stb.descKind) |-> roomOk);
endmodule

// File: tb/frame_fetch_dma_tb_top.sv
module frame_fetch_dma_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, descAddrWr, sofIrqEn, eofIrqEn, ufIrqEn;
  logic [31:0] descAddrIn;
  logic [1:0]  burstSel;
  logic [2:0]  flagClr;
  logic        memReq, memRdy, memRdValid;
  logic [31:0] memAddr, memRdData;
  logic [4:0]  memLen;
  logic        pixPop, activeVideo, pixEmpty, busy, palFlag;
  logic        sofFlag, eofFlag, ufFlag, irq;
  logic [31:0] pixData, frameId;
  logic        monPop, manPop;
  assign pixPop = monPop | manPop;

  frame_fetch_dma dut_i (
    .clk(clk), .rstN(rstN), .descAddrWr(descAddrWr), .descAddrIn(descAddrIn),
    .burstSel(burstSel), .sofIrqEn(sofIrqEn), .eofIrqEn(eofIrqEn), .ufIrqEn(ufIrqEn),
    .flagClr(flagClr), .memReq(memReq), .memRdy(memRdy), .memAddr(memAddr),
    .memLen(memLen), .memRdValid(memRdValid), .memRdData(memRdData),
    .pixPop(pixPop), .activeVideo(activeVideo), .pixData(pixData), .pixEmpty(pixEmpty),
    .busy(busy), .frameId(frameId), .palFlag(palFlag), .sofFlag(sofFlag),
    .eofFlag(eofFlag), .ufFlag(ufFlag), .irq(irq)
  );

  int checks = 0, errors = 0;
  int unsigned expQ[$];
  int unsigned lenLog[$];
  int unsigned reqLog[$];
  int unsigned descMem[int unsigned];
  bit popEn = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned dataOf(input int unsigned a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic int unsigned memWord(input int unsigned a);
    if (descMem.exists(a)) return descMem[a];
    return dataOf(a);
  endfunction

  // driver side of the scoreboard: expected frame words
  task automatic addFrame(input int unsigned base, input int n);
    for (int w = 0; w < n; w++) expQ.push_back(dataOf(base + 4 * w));
  endtask

  task automatic setDesc(input int unsigned at, input int unsigned nxt,
                         input int unsigned fa, input int unsigned id, input int unsigned cmd);
    descMem[at] = nxt; descMem[at + 4] = fa; descMem[at + 8] = id; descMem[at + 12] = cmd;
  endtask

  // memory responder
  int unsigned rA;
  int          rN;
  int          stallCnt = 0;
  initial begin
    memRdy = 0; memRdValid = 0; memRdData = 0;
    forever begin
      @(negedge clk);
      if (rstN && memReq) begin
        rA = memAddr; rN = memLen;
        repeat (stallCnt % 3) begin
          @(negedge clk);
          if (rstN) chk(memAddr == rA && memLen == rN, "R12", "held request", memAddr, rA);
        end
        stallCnt++;
        memRdy = 1; @(negedge clk); memRdy = 0;
        reqLog.push_back(rA);
        if (!descMem.exists(rA)) lenLog.push_back(rN);
        for (int w = 0; w < rN; w++) begin
          memRdValid = 1; memRdData = memWord(rA + 4 * w);
          @(negedge clk);
          memRdValid = 0;
          if (w % 3 == 1) @(negedge clk);
        end
      end
    end
  end

  // monitor side of the scoreboard
  int unsigned expW;
  initial begin
    monPop = 0;
    forever begin
      @(negedge clk);
      monPop = 0;
      if (rstN && popEn && !pixEmpty && expQ.size() > 0) begin
        expW = expQ.pop_front();
        chk(pixData == expW, "R2", "stream word", pixData, expW);
        monPop = 1;
      end
    end
  end

  task automatic doReset();
    rstN = 0; popEn = 0;
    repeat (60) @(negedge clk);
    expQ.delete(); lenLog.delete(); reqLog.delete();
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic pulseStart(input int unsigned a);
    descAddrIn = a; descAddrWr = 1; @(negedge clk); descAddrWr = 0;
  endtask

  task automatic waitDrain();
    for (int k = 0; k < 20000 && expQ.size() > 0; k++) @(negedge clk);
    chk(expQ.size() == 0, "R2", "all words delivered", expQ.size(), 0);
  endtask

  task automatic checkLens(input string req, input int unsigned e[$]);
    chk(lenLog.size() >= e.size(), req, "burst count", lenLog.size(), e.size());
    for (int i = 0; i < e.size() && i < lenLog.size(); i++)
      chk(lenLog[i] == e[i], req, "burst length", lenLog[i], e[i]);
  endtask

  function automatic int countReq(input int unsigned a);
    int c = 0;
    foreach (reqLog[i]) if (reqLog[i] == a) c++;
    return c;
  endfunction

  initial begin
    rstN = 0; descAddrWr = 0; descAddrIn = 0; burstSel = 0; flagClr = 0;
    sofIrqEn = 0; eofIrqEn = 0; ufIrqEn = 0; manPop = 0; activeVideo = 0;
    doReset();

    // R13 reset state
    chk(!memReq && !busy, "R13", "idle after reset", {memReq, busy}, 0);
    chk(pixEmpty, "R13", "FIFO empty", pixEmpty, 1);
    chk({sofFlag, eofFlag, ufFlag, irq} == 0, "R13", "flags clear", {sofFlag, eofFlag, ufFlag, irq}, 0);
    chk(frameId == 0 && !palFlag, "R13", "frame id clear", frameId, 0);

    // R8 underrun outside and inside active video
    manPop = 1; @(negedge clk); manPop = 0; @(negedge clk);
    chk(!ufFlag, "R8", "no underrun outside video", ufFlag, 0);
    activeVideo = 1; manPop = 1; @(negedge clk); manPop = 0; @(negedge clk);
    chk(ufFlag, "R8", "underrun in video", ufFlag, 1);
    chk(!irq, "R10", "masked underrun", irq, 0);
    ufIrqEn = 1; #1;
    chk(irq, "R10", "enabled underrun", irq, 1);
    // R9 set and clear in the same cycle: set wins
    manPop = 1; flagClr = 3'b100; @(negedge clk); manPop = 0; flagClr = 0; @(negedge clk);
    chk(ufFlag, "R9", "set beats clear", ufFlag, 1);
    flagClr = 3'b100; @(negedge clk); flagClr = 0; @(negedge clk);
    chk(!ufFlag && !irq, "R9", "clear alone", ufFlag, 0);
    activeVideo = 0; ufIrqEn = 0;

    // frame 1: self-linked, 21 words, bursts of 8, sof and eof requested
    setDesc(32'h100, 32'h100, 32'h1000, 32'hA1, 32'hC000_0015);
    burstSel = 2'd1; popEn = 1;
    addFrame(32'h1000, 21); addFrame(32'h1000, 21);
    pulseStart(32'h100);
    chk(busy, "R1", "busy after start", busy, 1);
    waitDrain();
    chk(reqLog.size() > 1 && reqLog[0] == 32'h100, "R1", "first request at descriptor",
        reqLog.size() > 0 ? reqLog[0] : 0, 32'h100);
    chk(reqLog.size() > 1 && reqLog[1] == 32'h1000, "R2", "data from frame address",
        reqLog.size() > 1 ? reqLog[1] : 0, 32'h1000);
    checkLens("R3", '{8, 8, 5, 8, 8, 5});
    chk(countReq(32'h100) >= 2, "R4", "self link refetched", countReq(32'h100), 2);
    chk(sofFlag && eofFlag, "R5", "sof and eof set", {sofFlag, eofFlag}, 3);
    chk(frameId == 32'hA1 && !palFlag, "R6", "frame id", frameId, 32'hA1);
    eofIrqEn = 1; #1;
    chk(irq, "R10", "eof interrupt", irq, 1);
    eofIrqEn = 0;

    // frame 2: chain A -> B -> B, bursts of 4, palette on A only
    doReset();
    setDesc(32'h200, 32'h300, 32'h2000, 32'hB1, 32'h1000_0006);
    setDesc(32'h300, 32'h300, 32'h3000, 32'hB2, 32'h4000_0005);
    burstSel = 2'd0; popEn = 1;
    addFrame(32'h2000, 6); addFrame(32'h3000, 5); addFrame(32'h3000, 5);
    pulseStart(32'h200);
    for (int k = 0; k < 400 && frameId != 32'hB1; k++) @(negedge clk);
    chk(frameId == 32'hB1 && palFlag, "R6", "palette marker loaded", palFlag, 1);
    pulseStart(32'h100);
    waitDrain();
    chk(countReq(32'h100) == 0, "R11", "start while busy ignored", countReq(32'h100), 0);
    chk(frameId == 32'hB2 && !palFlag, "R6", "second id", frameId, 32'hB2);
    chk(!sofFlag, "R5", "no sof without request", sofFlag, 0);
    chk(eofFlag, "R5", "eof from linked descriptor", eofFlag, 1);
    chk(countReq(32'h300) >= 2, "R4", "chain followed", countReq(32'h300), 2);
    checkLens("R3", '{4, 2, 4, 1, 4, 1});

    // frame 3: 40 words, bursts of 16, display stalled
    doReset();
    setDesc(32'h400, 32'h400, 32'h8000, 32'hC3, 32'h0000_0028);
    burstSel = 2'd2; popEn = 0;
    pulseStart(32'h400);
    repeat (300) @(negedge clk);
    chk(!memReq && busy, "R7", "stalled on full FIFO", memReq, 0);
    chk(lenLog.size() == 2, "R7", "bursts before stall", lenLog.size(), 2);
    addFrame(32'h8000, 40);
    popEn = 1;
    waitDrain();
    checkLens("R3", '{16, 16, 8});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule